// File: doc/BRIEF.md
# MAC Address Lookup Engine

This block is the address lookup table of a small Ethernet switch. Software fills a table of 68-bit entries one at a time, through three 32-bit staging words and an index/command register. It also sets a two-bit forwarding state for each port and turns the engine on through a control register. A clear command returns every entry to the free type in one step.

The forwarding path offers a destination MAC address together with the port the frame came in on. The engine walks the table from the lowest index, one entry per clock. It stops at the first entry of an address type whose 48-bit address equals the key. It then reports a hit flag, a drop flag and a port mask. The bit at position 40 of a hit entry, which is the group bit of the first octet, chooses how the upper bits are read: as one port number (unicast) or as a port mask (multicast). Only ports in the forward state ever appear in the mask. A miss floods to every forwarding port except the ingress port.

Top module: `mac_lookup_engine`

## Requirements
- R1: Writing byte address 0x20 with bit 31 set stores the staging words into the entry selected by the low index bits. The staging words are at 0x34, 0x38 and 0x3C. Word 0x34 supplies entry bits 67:64 from its low four bits, word 0x38 supplies bits 63:32, and word 0x3C supplies bits 31:0.
- R2: Writing 0x20 with bit 31 clear copies the selected entry into the three staging words by the next cycle, with the upper 28 bits of word 0x34 set to zero. Reading 0x20 returns the last index written.
- R3: The control register is at 0x08. Bit 31 enables lookups and bit 2 is a stored mode bit; both read back. Writing bit 30 makes it read as 1 for exactly one cycle, after which every entry is free (type 0) and every lookup misses.
- R4: Port p has a state register at 0x40 + 4·p. Only the low two bits are kept: 0 disabled, 1 blocking, 2 learning, 3 forwarding. All ports reset to 0.
- R5: A start that is accepted raises busy on the next cycle. Busy stays high for one cycle per entry examined, up to and including the first match or the last entry. Done is high for the single cycle after busy falls. Only entries whose type in bits 61:60 is 1 or 3 and whose bits 47:0 equal the key can match.
- R6: When several entries match, the lowest index wins.
- R7: On a hit whose bit 40 is set, the mask is entry bits 67:66 (bit 66 is port 0), ANDed with the set of forwarding ports.
- R8: On a hit whose bit 40 is clear and bit 65 is clear, the mask is the one-hot of the port number in bits 67:66, limited to forwarding ports. A port number that is not a port gives an empty mask with no drop.
- R9: On a hit whose bit 40 is clear and bit 65 is set, drop is 1 and the mask is empty.
- R10: On a miss, hit is 0, drop is 0, and the mask holds all forwarding ports except the ingress port.
- R11: While the engine is disabled, a start is ignored. While a scan is running, a start is ignored. In both cases busy and done stay as they would be without that start.
- R12: After reset, busy, done, hit, drop and mask are 0, all registers read 0, and all entries are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| lkStart | input | 1 | Request a lookup |
| lkMac | input | 48 | Destination address key |
| lkIngress | input | 1 | Ingress port number |
| lkBusy | output | 1 | Scan in progress |
| lkDone | output | 1 | One-cycle result strobe |
| lkHit | output | 1 | Last result: an entry matched |
| lkDrop | output | 1 | Last result: frame is to be dropped |
| lkMask | output | 2 | Last result: egress port mask |

## Verification
A start sampled on one edge shows busy from the next cycle. A match at index i ends the scan i+1 cycles later, and a miss ends it after one cycle per table entry. Done, hit, drop and mask change together on the edge that ends the scan. Register writes take effect on their own edge, a staging load is visible one cycle after its command, and the clear bit reads back high only in the cycle right after it is written. The bench mirrors these edges in a behavioural model that steps on every rising edge. It compares all lookup outputs on the falling edge of every cycle, and separately counts busy cycles and reads registers at the cycle offsets listed above.

// File: rtl/mle_pkg.sv
package mle_pkg;

  // Register byte addresses
  localparam logic [7:0] REG_CTRL      = 8'h08;
  localparam logic [7:0] REG_TBL_CMD   = 8'h20;
  localparam logic [7:0] REG_WORD_HI   = 8'h34;
  localparam logic [7:0] REG_WORD_MID  = 8'h38;
  localparam logic [7:0] REG_WORD_LO   = 8'h3C;
  localparam int         REG_PORT_BASE = 8'h40;

  // Entry field positions
  localparam int TYPE_LSB   = 60;
  localparam int GROUP_BIT  = 40;
  localparam int BLOCK_BIT  = 65;
  localparam int PORT_LSB   = 66;
  localparam int MAC_W      = 48;

  localparam logic [1:0] TYPE_FREE      = 2'd0;
  localparam logic [1:0] TYPE_ADDR      = 2'd1;
  localparam logic [1:0] TYPE_VLAN_ADDR = 2'd3;
  localparam logic [1:0] STATE_FORWARD  = 2'd3;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic scanStart;
    logic scanStep;
    logic scanFinish;
  } scanStrobe_t;

endpackage

// File: rtl/mle_control.sv
module mle_control
  import mle_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lkStart,
  input  logic        engEnable,
  input  logic        clearing,
  input  logic        curMatch,
  input  logic        curLast,
  output scanStrobe_t strobe,
  output logic        busy
);

  typedef enum logic {S_IDLE, S_SCAN} scanState_t;
  scanState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (lkStart && engEnable && !clearing) begin
          strobe.scanStart = 1'b1;
          stateNext        = S_SCAN;
        end
      end
      S_SCAN: begin
        if (curMatch || curLast) begin
          strobe.scanFinish = 1'b1;
          stateNext         = S_IDLE;
        end else begin
          strobe.scanStep = 1'b1;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign busy = (state == S_SCAN);

  // R11: a disabled engine never leaves idle
  assert_disabled_stays_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !engEnable) |=> (state == S_IDLE));

  // R5: a scan step is only taken while the entry under test neither matches nor is the last
  assert_step_only_unmatched_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && curMatch) |=> !busy);

endmodule

// File: rtl/mle_datapath.sv
module mle_datapath
  import mle_pkg::*;
#(
  parameter  int NUM_ENTRIES = 16,   // power of two
  parameter  int NUM_PORTS   = 2,
  localparam int ING_W       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [MAC_W-1:0]  lkMac,
  input  logic [ING_W-1:0]  lkIngress,
  input  scanStrobe_t       strobe,
  output logic              curMatch,
  output logic              curLast,
  output logic              engEnable,
  output logic              clearing,
  output logic              resDone,
  output logic              resHit,
  output logic              resDrop,
  output logic [NUM_PORTS-1:0] resMask
);

  localparam int IDX_W   = $clog2(NUM_ENTRIES);
  localparam int ENTRY_W = PORT_LSB + NUM_PORTS;
  localparam int HI_W    = ENTRY_W - 64;
  localparam int PF_W    = NUM_PORTS;

  // ---------------- storage and software-visible state ----------------
  logic [ENTRY_W-1:0] tbl [NUM_ENTRIES];
  logic [31:0]        wordHi, wordMid, wordLo;
  logic               vlanAware;
  logic [1:0]         portState [NUM_PORTS];
  logic [IDX_W-1:0]   tblIdx;

  logic               ctrlWr, cmdWr, hiWr, midWr, loWr;
  logic [IDX_W-1:0]   cmdIdx;
  logic [ENTRY_W-1:0] stagedEntry;

  assign ctrlWr      = regWrEn && (regAddr == REG_CTRL);
  assign cmdWr       = regWrEn && (regAddr == REG_TBL_CMD);
  assign hiWr        = regWrEn && (regAddr == REG_WORD_HI);
  assign midWr       = regWrEn && (regAddr == REG_WORD_MID);
  assign loWr        = regWrEn && (regAddr == REG_WORD_LO);
  assign cmdIdx      = regWrData[IDX_W-1:0];
  assign stagedEntry = {wordHi[HI_W-1:0], wordMid, wordLo};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) tbl[i] <= '0;
    end else if (clearing) begin
      for (int i = 0; i < NUM_ENTRIES; i++) tbl[i] <= '0;
    end else if (cmdWr && regWrData[31]) begin
      tbl[cmdIdx] <= stagedEntry;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordHi  <= '0;
      wordMid <= '0;
      wordLo  <= '0;
      tblIdx  <= '0;
    end else begin
      if (cmdWr) tblIdx <= cmdIdx;
      if (cmdWr && !regWrData[31]) begin
        wordHi  <= 32'(tbl[cmdIdx][ENTRY_W-1:64]);
        wordMid <= tbl[cmdIdx][63:32];
        wordLo  <= tbl[cmdIdx][31:0];
      end else begin
        if (hiWr)  wordHi  <= regWrData;
        if (midWr) wordMid <= regWrData;
        if (loWr)  wordLo  <= regWrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      engEnable <= 1'b0;
      vlanAware <= 1'b0;
      clearing  <= 1'b0;
    end else begin
      clearing <= ctrlWr && regWrData[30];
      if (ctrlWr) begin
        engEnable <= regWrData[31];
        vlanAware <= regWrData[2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PORTS; p++) portState[p] <= 2'd0;
    end else if (regWrEn) begin
      for (int p = 0; p < NUM_PORTS; p++)
        if (regAddr == 8'(REG_PORT_BASE + 4 * p)) portState[p] <= regWrData[1:0];
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == REG_CTRL)     regRdData = {engEnable, clearing, 27'd0, vlanAware, 2'd0};
    if (regAddr == REG_TBL_CMD)  regRdData = 32'(tblIdx);
    if (regAddr == REG_WORD_HI)  regRdData = wordHi;
    if (regAddr == REG_WORD_MID) regRdData = wordMid;
    if (regAddr == REG_WORD_LO)  regRdData = wordLo;
    for (int p = 0; p < NUM_PORTS; p++)
      if (regAddr == 8'(REG_PORT_BASE + 4 * p)) regRdData = {30'd0, portState[p]};
  end

  // ---------------- scan datapath ----------------
  logic [IDX_W-1:0]     scanIdx;
  logic [MAC_W-1:0]     keyMac;
  logic [ING_W-1:0]     keyIng;
  logic [1:0]           curType;
  logic [PF_W-1:0]      portField;
  logic                 curGroup, curBlocked;
  logic [NUM_PORTS-1:0] fwdMask, uniHot, ingHot;
  logic [NUM_PORTS-1:0] nextMask;
  logic                 nextDrop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanIdx <= '0;
      keyMac  <= '0;
      keyIng  <= '0;
    end else if (strobe.scanStart) begin
      scanIdx <= '0;
      keyMac  <= lkMac;
      keyIng  <= lkIngress;
    end else if (strobe.scanStep) begin
      scanIdx <= scanIdx + 1'b1;
    end
  end

  assign curType    = tbl[scanIdx][TYPE_LSB +: 2];
  assign portField  = tbl[scanIdx][PORT_LSB +: PF_W];
  assign curGroup   = tbl[scanIdx][GROUP_BIT];
  assign curBlocked = tbl[scanIdx][BLOCK_BIT];
  assign curMatch   = ((curType == TYPE_ADDR) || (curType == TYPE_VLAN_ADDR)) &&
                      (tbl[scanIdx][MAC_W-1:0] == keyMac);
  assign curLast    = (scanIdx == IDX_W'(NUM_ENTRIES - 1));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign fwdMask[p] = (portState[p] == STATE_FORWARD);
    assign uniHot[p]  = (portField == PF_W'(p));
    assign ingHot[p]  = (keyIng == ING_W'(p));
  end

  always_comb begin
    nextDrop = 1'b0;
    nextMask = '0;
    if (!curMatch) begin
      nextMask = fwdMask & ~ingHot;
    end else if (curGroup) begin
      nextMask = portField & fwdMask;
    end else if (curBlocked) begin
      nextDrop = 1'b1;
    end else begin
      nextMask = uniHot & fwdMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resDone <= 1'b0;
      resHit  <= 1'b0;
      resDrop <= 1'b0;
      resMask <= '0;
    end else begin
      resDone <= strobe.scanFinish;
      if (strobe.scanFinish) begin
        resHit  <= curMatch;
        resDrop <= nextDrop;
        resMask <= nextMask;
      end
    end
  end

  // ---------------- assertions ----------------
  logic allFree;
  always_comb begin
    allFree = 1'b1;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (tbl[i][TYPE_LSB +: 2] != TYPE_FREE) allFree = 1'b0;
  end

  assert_clear_frees_all_R3: assert property (@(posedge clk) disable iff (!rstN)
    clearing |=> allFree);

  assert_drop_needs_hit_R9: assert property (@(posedge clk) disable iff (!rstN)
    resDrop |-> (resHit && resMask == '0));

  assert_mask_only_forwarding_R7: assert property (@(posedge clk) disable iff (!rstN)
    resDone |-> ((resMask & ~$past(fwdMask)) == '0));

  assert_start_rewinds_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.scanStart |=> (scanIdx == '0));

endmodule

// File: rtl/mac_lookup_engine.sv
module mac_lookup_engine
  import mle_pkg::*;
#(
  parameter  int NUM_ENTRIES = 16,
  parameter  int NUM_PORTS   = 2,
  localparam int ING_W       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [7:0]           regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic                 lkStart,
  input  logic [47:0]          lkMac,
  input  logic [ING_W-1:0]     lkIngress,
  output logic                 lkBusy,
  output logic                 lkDone,
  output logic                 lkHit,
  output logic                 lkDrop,
  output logic [NUM_PORTS-1:0] lkMask
);

  scanStrobe_t strobe;
  logic curMatch, curLast, engEnable, clearing;

  mle_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .lkStart   (lkStart),
    .engEnable (engEnable),
    .clearing  (clearing),
    .curMatch  (curMatch),
    .curLast   (curLast),
    .strobe    (strobe),
    .busy      (lkBusy)
  );

  mle_datapath #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .NUM_PORTS   (NUM_PORTS)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .lkMac     (lkMac),
    .lkIngress (lkIngress),
    .strobe    (strobe),
    .curMatch  (curMatch),
    .curLast   (curLast),
    .engEnable (engEnable),
    .clearing  (clearing),
    .resDone   (lkDone),
    .resHit    (lkHit),
    .resDrop   (lkDrop),
    .resMask   (lkMask)
  );

  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    lkDone |-> (!lkBusy && $past(lkBusy)));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    lkDone |=> !lkDone);

endmodule

// File: tb/mac_lookup_engine_bench.sv
module mac_lookup_engine_bench;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        lkStart = 1'b0;
  logic [47:0] lkMac = '0;
  logic        lkIngress = 1'b0;
  logic        lkBusy, lkDone, lkHit, lkDrop;
  logic [1:0]  lkMask;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  mac_lookup_engine u_mac_lookup_engine (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .lkStart(lkStart),
    .lkMac(lkMac), .lkIngress(lkIngress), .lkBusy(lkBusy), .lkDone(lkDone),
    .lkHit(lkHit), .lkDrop(lkDrop), .lkMask(lkMask)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [67:0] mTab [N];
  logic [31:0] mW [3];
  bit          mEn, mClr;
  logic [1:0]  mPs [2];
  bit          mBusy, mDone, mHit, mDrop;
  int          mIdx, mIng;
  logic [47:0] mKey;
  logic [1:0]  mMask;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) mTab[i] = '0;
      for (int i = 0; i < 3; i++) mW[i] = '0;
      mEn = 0; mClr = 0; mPs[0] = 0; mPs[1] = 0;
      mBusy = 0; mDone = 0; mHit = 0; mDrop = 0; mMask = 0; mIdx = 0; mIng = 0; mKey = 0;
    end else begin
      logic [67:0] e;
      logic [1:0]  fwd;
      bit          match, nextClr;
      fwd = {mPs[1] == 2'd3, mPs[0] == 2'd3};
      mDone = 0;
      if (mBusy) begin
        e = mTab[mIdx];
        match = (e[61:60] == 2'd1 || e[61:60] == 2'd3) && e[47:0] == mKey;
        if (match || mIdx == N - 1) begin
          mBusy = 0; mDone = 1; mHit = match; mDrop = 0;
          if (!match) mMask = fwd & ~(2'b01 << mIng);
          else if (e[40]) mMask = e[67:66] & fwd;
          else if (e[65]) begin mDrop = 1; mMask = 0; end
          else if (e[67:66] < 2) mMask = (2'b01 << e[67:66]) & fwd;
          else mMask = 0;
        end else mIdx++;
      end else if (lkStart && mEn && !mClr) begin
        mBusy = 1; mIdx = 0; mKey = lkMac; mIng = int'(lkIngress);
      end
      nextClr = 0;
      if (regWrEn) begin
        case (regAddr)
          8'h08: begin mEn = regWrData[31]; nextClr = regWrData[30]; end
          8'h20: if (regWrData[31]) mTab[regWrData[3:0]] = {mW[0][3:0], mW[1], mW[2]};
                 else begin
                   mW[0] = {28'd0, mTab[regWrData[3:0]][67:64]};
                   mW[1] = mTab[regWrData[3:0]][63:32];
                   mW[2] = mTab[regWrData[3:0]][31:0];
                 end
          8'h34: mW[0] = regWrData;
          8'h38: mW[1] = regWrData;
          8'h3C: mW[2] = regWrData;
          8'h40: mPs[0] = regWrData[1:0];
          8'h44: mPs[1] = regWrData[1:0];
          default: ;
        endcase
      end
      if (mClr) for (int i = 0; i < N; i++) mTab[i] = '0;
      mClr = nextClr;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check("R5 busy", 32'(lkBusy), 32'(mBusy));
      check("R5 done", 32'(lkDone), 32'(mDone));
      check("R6 hit", 32'(lkHit), 32'(mHit));
      check("R9 drop", 32'(lkDrop), 32'(mDrop));
      check("R10 mask", 32'(lkMask), 32'(mMask));
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wrReg(logic [7:0] a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [7:0] a, logic [31:0] exp, string tag);
    regAddr = a;
    #1 check(tag, regRdData, exp);
    @(negedge clk);
  endtask

  task automatic putEntry(int idx, logic [67:0] e);
    wrReg(8'h34, {28'd0, e[67:64]});
    wrReg(8'h38, e[63:32]);
    wrReg(8'h3C, e[31:0]);
    wrReg(8'h20, 32'h8000_0000 | 32'(idx));
  endtask

  function automatic logic [67:0] uni(logic [47:0] mac, logic [1:0] pn, bit blk, logic [1:0] ty);
    logic [67:0] e = '0;
    e[61:60] = ty; e[47:0] = mac; e[67:66] = pn; e[65] = blk;
    return e;
  endfunction

  function automatic logic [67:0] grp(logic [47:0] mac, logic [1:0] msk);
    logic [67:0] e = '0;
    e[61:60] = 2'd1; e[63:62] = 2'd3; e[47:0] = mac; e[67:66] = msk;
    return e;
  endfunction

  task automatic lookup(logic [47:0] mac, logic ing, bit eHit, bit eDrop,
                        logic [1:0] eMask, int eBusy, string tag);
    int cnt = 0;
    lkStart = 1'b1; lkMac = mac; lkIngress = ing;
    @(negedge clk);
    lkStart = 1'b0;
    while (!lkDone && cnt < 100) begin
      if (lkBusy) cnt++;
      @(negedge clk);
    end
    check({tag, " busy cycles"}, 32'(cnt), 32'(eBusy));
    check({tag, " hit"}, 32'(lkHit), 32'(eHit));
    check({tag, " drop"}, 32'(lkDrop), 32'(eDrop));
    check({tag, " mask"}, 32'(lkMask), 32'(eMask));
    @(negedge clk);
  endtask

  localparam logic [47:0] MAC_A = 48'h0011_2233_4455;
  localparam logic [47:0] MAC_B = 48'h0100_5E00_0001;
  localparam logic [47:0] MAC_C = 48'h0000_AA00_0001;
  localparam logic [47:0] MAC_D = 48'h0000_BB00_0002;
  localparam logic [47:0] MAC_E = 48'h0000_CC00_0003;
  localparam logic [47:0] MAC_F = 48'h0000_DD00_0004;

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 busy", 32'(lkBusy), 0);
    check("R12 done", 32'(lkDone), 0);
    check("R12 hit/drop/mask", {29'd0, lkHit, lkDrop, 1'b0} | 32'(lkMask), 0);
    rstN = 1'b1;
    @(negedge clk);
    rdReg(8'h08, 32'h0, "R12 control");
    rdReg(8'h44, 32'h0, "R12 port1");
    rdReg(8'h34, 32'h0, "R12 word");

    // R4: port state registers
    wrReg(8'h44, 32'hFFFF_FFFE);
    rdReg(8'h44, 32'h2, "R4 port1 low bits");
    wrReg(8'h40, 32'h3);
    wrReg(8'h44, 32'h3);
    rdReg(8'h40, 32'h3, "R4 port0");

    // R3: enable and stored mode bit
    wrReg(8'h08, 32'h8000_0004);
    rdReg(8'h08, 32'h8000_0004, "R3 control readback");

    // R1: fill the table
    putEntry(1, uni(MAC_E, 2'd0, 0, 2'd2));
    putEntry(2, uni(MAC_A, 2'd1, 0, 2'd1));
    putEntry(3, grp(MAC_B, 2'b11));
    putEntry(4, uni(MAC_C, 2'd0, 1, 2'd1));
    putEntry(5, uni(MAC_A, 2'd0, 0, 2'd1));
    putEntry(6, uni(MAC_D, 2'd3, 0, 2'd1));
    putEntry(7, uni(MAC_F, 2'd0, 0, 2'd3));

    // R2: read back entry 3 through the staging words
    wrReg(8'h34, 32'hFFFF_FFFF);
    wrReg(8'h20, 32'h3);
    rdReg(8'h34, 32'h0000_000C, "R2 word hi");
    rdReg(8'h38, 32'hD000_0100, "R2 word mid");
    rdReg(8'h3C, 32'h5E00_0001, "R2 word lo");
    rdReg(8'h20, 32'h3, "R2 index");

    // lookups with both ports forwarding
    lookup(MAC_A, 1'b0, 1, 0, 2'b10, 3, "R6 R8 first unicast match");
    lookup(MAC_B, 1'b0, 1, 0, 2'b11, 4, "R7 group mask");
    lookup(MAC_C, 1'b0, 1, 1, 2'b00, 5, "R9 blocked drop");
    lookup(MAC_D, 1'b0, 1, 0, 2'b00, 7, "R8 out-of-range port");
    lookup(MAC_E, 1'b0, 0, 0, 2'b10, N, "R10 R5 miss skips vlan type");
    lookup(MAC_F, 1'b1, 1, 0, 2'b01, 8, "R5 type 3 matches");

    // port 1 learning: excluded from masks
    wrReg(8'h44, 32'h2);
    lookup(MAC_B, 1'b0, 1, 0, 2'b01, 4, "R7 gated by state");
    lookup(MAC_E, 1'b1, 0, 0, 2'b01, N, "R10 flood ingress 1");
    lookup(MAC_E, 1'b0, 0, 0, 2'b00, N, "R10 flood excludes ingress");
    wrReg(8'h44, 32'h3);

    // R11: start during a scan is ignored
    begin
      int dones = 0;
      lkStart = 1'b1; lkMac = MAC_E; lkIngress = 1'b0;
      @(negedge clk);
      lkStart = 1'b0;
      repeat (3) @(negedge clk);
      lkStart = 1'b1; lkMac = MAC_A;
      @(negedge clk);
      lkStart = 1'b0;
      for (int k = 0; k < N + 6; k++) begin
        if (lkDone) dones++;
        @(negedge clk);
      end
      check("R11 one result for overlapping start", 32'(dones), 1);
      check("R11 result belongs to first key", 32'(lkHit), 0);
      check("R11 result mask", 32'(lkMask), 32'b10);
    end

    // R11: disabled engine ignores start
    wrReg(8'h08, 32'h0);
    lkStart = 1'b1; lkMac = MAC_A;
    @(negedge clk);
    lkStart = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 6; k++) begin
        if (lkBusy || lkDone) seen++;
        @(negedge clk);
      end
      check("R11 disabled no activity", 32'(seen), 0);
    end

    // R3: clear-all
    wrReg(8'h08, 32'hC000_0000);
    rdReg(8'h08, 32'hC000_0000, "R3 clear bit high one cycle");
    rdReg(8'h08, 32'h8000_0000, "R3 clear bit self-cleared");
    lookup(MAC_A, 1'b0, 0, 0, 2'b10, N, "R3 miss after clear");
    wrReg(8'h20, 32'h2);
    rdReg(8'h38, 32'h0, "R3 entry freed");

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule